// File: doc/BRIEF.md
# Interleaved Row Memory with Double-Buffered Staging

This block presents a set of identical single-port banks as one flat word memory. The low address bits pick a bank and the high bits pick a row, so word address A lives in bank (A mod NBANK) at row (A div NBANK). Consecutive addresses therefore fall in neighbouring banks. Data never moves one word at a time between the banks and the outside. A command moves a whole row, one word per bank, in a single parallel step between the banks and a set of NBANK staging registers.

A host port walks the staging registers in index order, one word per valid/ready handshake. It can read or overwrite each register. There are two staging sets. While the host streams one set, a row command can fill or drain the other. When the host finishes the last word, the two sets trade roles. A typical use is to load a row, let the host stream or patch it, and then write the patched set back to a row.

Top module: `ilv_row_mem`

## Requirements
- R1: After reset, cmd_busy is 0, host_ready is 0 and host_idx is 0.
- R2: A command accepted while cmd_busy is low (cmd_valid high at a clock edge) makes cmd_busy high for exactly the two following cycles: issue, then capture.
- R3: A command presented while cmd_busy is high is ignored. It neither extends the transfer nor changes the row being moved.
- R4: A row read (cmd_wr=0) of row R loads staging register i with the word at flat address R*NBANK+i, which is bank i, row R.
- R5: A row write (cmd_wr=1) of row R stores every register of the set the host most recently left into row R of all banks in one step. Register i goes to flat address R*NBANK+i.
- R6: host_ready stays low until a row read has filled the host-side set. It rises in the same cycle that cmd_busy falls after that read.
- R7: Each handshake (host_valid and host_ready) advances host_idx by one. host_rdata shows register host_idx of the host-side set, and host_we=1 overwrites that register with host_wdata. After index NBANK-1, host_idx returns to 0.
- R8: The handshake on index NBANK-1 is withheld (host_ready low) while cmd_busy or cmd_valid is high.
- R9: A row read issued while the host-side set is full fills the other set. After the final handshake on the current set, host_ready stays high and the next word shown is word 0 of the new row.
- R10: After the final handshake, the set that was left is marked empty. If the other set was never filled, host_ready goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Row command request |
| cmd_wr | input | 1 | 1 = write staging set to row, 0 = read row into staging set |
| cmd_row | input | ROW_BITS | Row (high address bits) for the command |
| cmd_busy | output | 1 | Row transfer in flight; commands are ignored |
| host_valid | input | 1 | Host requests one word transfer |
| host_we | input | 1 | 1 = overwrite current register, 0 = read only |
| host_wdata | input | WORD_W | Word written by the host |
| host_ready | output | 1 | Host-side set holds data and may advance |
| host_rdata | output | WORD_W | Current register of the host-side set |
| host_idx | output | BANK_BITS | Index of the current register |

## Verification
The bench presents a command in the first busy cycle. A design that restarted on it would stay busy too long or deliver the wrong row. It places a final-word request in the same cycle as a new row read. A design that swapped roles early would stream a half-loaded set or capture into the set the host is reading. It issues a row read while the host is mid-row and checks that the next row appears with no gap right after the last word. It also checks that a set once consumed reads as empty, so a design that forgot to clear it would replay stale words. Each row is filled through write-back and then read again, so a bank/row swap in the address mapping shows up as misplaced words.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_ISSUE = 2'd1,
    XF_CAPT  = 2'd2
  } xf_state_e;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROW_BITS = 3,
  parameter int WORD_W   = 8
) (
  input  logic                clk,
  input  logic                en,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata
);
  localparam int NROW = 1 << ROW_BITS;

  logic [WORD_W-1:0] mem_q [NROW];
  logic [WORD_W-1:0] rdata_q;

  // single port, one-cycle read latency, no reset on storage
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[row] <= wdata;
      else    rdata_q    <= mem_q[row];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ilv_xfer_ctl.sv
module ilv_xfer_ctl
  import ilv_pkg::*;
#(
  parameter int ROW_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_wr,
  input  logic [ROW_BITS-1:0] cmd_row,
  input  logic                act_sel,
  input  logic                act_full,
  output logic                busy,
  output logic                bank_en,
  output logic                bank_we,
  output logic [ROW_BITS-1:0] bank_row,
  output logic                cap_en,
  output logic                xfer_set
);
  xf_state_e           st_q, st_d;
  logic                wr_q, wr_d;
  logic                set_q, set_d;
  logic [ROW_BITS-1:0] row_q, row_d;
  logic                accept;

  assign accept = cmd_valid && (st_q == XF_IDLE);

  always_comb begin
    st_d  = st_q;
    wr_d  = wr_q;
    set_d = set_q;
    row_d = row_q;
    unique case (st_q)
      XF_IDLE: begin
        if (accept) begin
          st_d  = XF_ISSUE;
          wr_d  = cmd_wr;
          row_d = cmd_row;
          // writes drain the set the host left; reads fill the host set if empty
          set_d = (cmd_wr || act_full) ? ~act_sel : act_sel;
        end
      end
      XF_ISSUE: st_d = XF_CAPT;
      XF_CAPT:  st_d = XF_IDLE;
      default:  st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XF_IDLE;
      wr_q  <= 1'b0;
      set_q <= 1'b0;
      row_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wr_q  <= wr_d;
        set_q <= set_d;
        row_q <= row_d;
      end
    end
  end

  assign busy     = (st_q != XF_IDLE);
  assign bank_en  = (st_q == XF_ISSUE);
  assign bank_we  = bank_en && wr_q;
  assign bank_row = row_q;
  assign cap_en   = (st_q == XF_CAPT) && !wr_q;
  assign xfer_set = set_q;

  // R2: issue is always followed by capture, capture by idle
  a_r2_issue_then_capt: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XF_ISSUE) |=> (st_q == XF_CAPT));
  a_r2_capt_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XF_CAPT) |=> (st_q == XF_IDLE));
  // R3: a request during a transfer never restarts it
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (st_q != XF_ISSUE));

endmodule

// File: rtl/ilv_stage_buf.sv
module ilv_stage_buf #(
  parameter int BANK_BITS = 2,
  parameter int WORD_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           host_valid,
  input  logic                           host_we,
  input  logic [WORD_W-1:0]              host_wdata,
  output logic                           host_ready,
  output logic [WORD_W-1:0]              host_rdata,
  output logic [BANK_BITS-1:0]           host_idx,
  input  logic                           busy,
  input  logic                           cmd_valid,
  input  logic                           cap_en,
  input  logic                           xfer_set,
  input  logic [(1<<BANK_BITS)*WORD_W-1:0] cap_data,
  output logic [(1<<BANK_BITS)*WORD_W-1:0] bank_wdata,
  output logic                           act_sel,
  output logic                           act_full
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam logic [BANK_BITS-1:0] LAST_IDX = BANK_BITS'(NBANK - 1);

  logic [WORD_W-1:0]    buf_q [2][NBANK];
  logic [WORD_W-1:0]    buf_d [2][NBANK];
  logic [1:0]           full_q, full_d;
  logic                 act_q, act_d;
  logic [BANK_BITS-1:0] idx_q, idx_d;
  logic                 at_last, hs, swap;

  assign at_last    = (idx_q == LAST_IDX);
  assign host_ready = full_q[act_q] && !(at_last && (busy || cmd_valid));
  assign hs         = host_valid && host_ready;
  assign swap       = hs && at_last;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    act_d  = act_q;
    idx_d  = idx_q;
    if (cap_en) begin
      for (int i = 0; i < NBANK; i++) begin
        buf_d[xfer_set][i] = cap_data[i*WORD_W +: WORD_W];
      end
      full_d[xfer_set] = 1'b1;
    end
    if (hs) begin
      if (host_we) buf_d[act_q][idx_q] = host_wdata;
      idx_d = at_last ? '0 : idx_q + 1'b1;
    end
    if (swap) begin
      full_d[act_q] = 1'b0;
      act_d         = ~act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      act_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      act_q  <= act_d;
      idx_q  <= idx_d;
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    buf_q <= buf_d;
  end

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_wdata
    assign bank_wdata[gi*WORD_W +: WORD_W] = buf_q[xfer_set][gi];
  end

  assign host_rdata = buf_q[act_q][idx_q];
  assign host_idx   = idx_q;
  assign act_sel    = act_q;
  assign act_full   = full_q[act_q];

  // R8: the final handshake only happens with the bank side quiet
  a_r8_last_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && at_last) |-> (!busy && !cmd_valid));
  // R7: index steps by one on each handshake
  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !at_last) |=> (idx_q == $past(idx_q) + 1'b1));
  // R7: index wraps and roles trade after the last word
  a_r7_wrap_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && at_last) |=> ((idx_q == '0) && (act_q != $past(act_q))));
  // R10: the set that was left is empty afterwards
  a_r10_left_empty: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !full_q[$past(act_q)]);
  // R4: capture never lands on the set the host is streaming
  a_r4_cap_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && full_q[act_q]) |-> (xfer_set != act_q));

endmodule

// File: rtl/ilv_row_mem.sv
module ilv_row_mem #(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 3,
  parameter int WORD_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_wr,
  input  logic [ROW_BITS-1:0]  cmd_row,
  output logic                 cmd_busy,
  input  logic                 host_valid,
  input  logic                 host_we,
  input  logic [WORD_W-1:0]    host_wdata,
  output logic                 host_ready,
  output logic [WORD_W-1:0]    host_rdata,
  output logic [BANK_BITS-1:0] host_idx
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int ROWW  = NBANK * WORD_W;

  logic                rst_s1_q, rst_s2_q, rst_sync_n;
  logic                bank_en, bank_we, cap_en, xfer_set;
  logic                act_sel, act_full;
  logic [ROW_BITS-1:0] bank_row;
  logic [ROWW-1:0]     row_rdata, row_wdata;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_sync_n = rst_s2_q;

  ilv_xfer_ctl #(.ROW_BITS(ROW_BITS)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_wr    (cmd_wr),
    .cmd_row   (cmd_row),
    .act_sel   (act_sel),
    .act_full  (act_full),
    .busy      (cmd_busy),
    .bank_en   (bank_en),
    .bank_we   (bank_we),
    .bank_row  (bank_row),
    .cap_en    (cap_en),
    .xfer_set  (xfer_set)
  );

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    ilv_bank #(.ROW_BITS(ROW_BITS), .WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .en    (bank_en),
      .we    (bank_we),
      .row   (bank_row),
      .wdata (row_wdata[gb*WORD_W +: WORD_W]),
      .rdata (row_rdata[gb*WORD_W +: WORD_W])
    );
  end

  ilv_stage_buf #(.BANK_BITS(BANK_BITS), .WORD_W(WORD_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_valid (host_valid),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .host_idx   (host_idx),
    .busy       (cmd_busy),
    .cmd_valid  (cmd_valid),
    .cap_en     (cap_en),
    .xfer_set   (xfer_set),
    .cap_data   (row_rdata),
    .bank_wdata (row_wdata),
    .act_sel    (act_sel),
    .act_full   (act_full)
  );

  // R6: the host side opens only once a set is full
  a_r6_ready_needs_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_ready |-> act_full);
  // R1: reset leaves the host side closed
  a_r1_reset_closed: assert property (@(posedge clk)
    !rst_sync_n |-> (!host_ready && !cmd_busy));

endmodule

// File: tb/ilv_row_mem_bench.sv
`timescale 1ns/1ps
module ilv_row_mem_bench;
  localparam int BB = 2, RB = 3, W = 8;
  localparam int NB = 1 << BB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_wr;
  logic [RB-1:0] cmd_row;
  logic          cmd_busy;
  logic          host_valid, host_we;
  logic [W-1:0]  host_wdata, host_rdata;
  logic          host_ready;
  logic [BB-1:0] host_idx;

  logic [W-1:0] ref_mem [NB << RB];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ilv_row_mem #(.BANK_BITS(BB), .ROW_BITS(RB), .WORD_W(W)) u_ilv_row_mem (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_row(cmd_row), .cmd_busy(cmd_busy), .host_valid(host_valid),
    .host_we(host_we), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_idx(host_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // entry and exit: just after a falling edge; checks R2 timing
  task automatic do_cmd(input logic wr, input logic [RB-1:0] row);
    cmd_valid = 1'b1; cmd_wr = wr; cmd_row = row;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; #1;
    chk("R2 busy issue", cmd_busy, 1);
    @(negedge clk); #1;
    chk("R2 busy capt", cmd_busy, 1);
    @(negedge clk); #1;
    chk("R2 busy done", cmd_busy, 0);
  endtask

  task automatic host_word(input logic we, input logic [W-1:0] wd,
                           output logic [W-1:0] rd, output logic [BB-1:0] ix);
    host_valid = 1'b1; host_we = we; host_wdata = wd; #1;
    while (!host_ready) begin @(negedge clk); #1; end
    rd = host_rdata; ix = host_idx;
    @(posedge clk); @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0; #1;
  endtask

  task automatic read_row(input logic [RB-1:0] row, input string tag);
    logic [W-1:0] rd; logic [BB-1:0] ix;
    for (int i = 0; i < NB; i++) begin
      host_word(1'b0, '0, rd, ix);
      chk({tag, " R4 word"}, rd, ref_mem[row*NB+i]);
      chk({tag, " R7 idx"}, ix, i);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_valid = 0; cmd_wr = 0; cmd_row = 0;
    host_valid = 0; host_we = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk("R1 busy", cmd_busy, 0);
    chk("R1 ready", host_ready, 0);
    chk("R1 idx", host_idx, 0);
  endtask

  // load a row, overwrite it through the host, write it back (R5)
  task automatic write_row(input logic [RB-1:0] row, input int seed);
    logic [W-1:0] rd; logic [BB-1:0] ix;
    do_cmd(1'b0, row);
    chk("R6 ready after fill", host_ready, 1);
    for (int i = 0; i < NB; i++) begin
      ref_mem[row*NB+i] = W'(seed + (row*NB+i)*37 + 11);
      host_word(1'b1, ref_mem[row*NB+i], rd, ix);
    end
    chk("R10 ready low after leave", host_ready, 0);
    chk("R7 idx wrap", host_idx, 0);
    do_cmd(1'b1, row);
    chk("R10 still empty after write", host_ready, 0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < (1 << RB); r++) write_row(RB'(r), 5);
  endtask

  task automatic t_read(input logic [RB-1:0] row);
    chk("R6 ready low before read", host_ready, 0);
    do_cmd(1'b0, row);
    chk("R6 ready with busy fall", host_ready, 1);
    read_row(row, "read");
    chk("R10 empty after row", host_ready, 0);
  endtask

  task automatic t_ignore();
    cmd_valid = 1'b1; cmd_wr = 0; cmd_row = 3'd2;
    @(posedge clk); @(negedge clk);
    cmd_row = 3'd5;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; #1;
    chk("R3 busy capt", cmd_busy, 1);
    @(negedge clk); #1;
    chk("R3 no restart", cmd_busy, 0);
    read_row(3'd2, "R3 ignored row");
  endtask

  task automatic t_double();
    logic [W-1:0] rd; logic [BB-1:0] ix;
    do_cmd(1'b0, 3'd1);
    host_word(1'b0, '0, rd, ix); chk("R9 w0", rd, ref_mem[1*NB+0]);
    host_word(1'b0, '0, rd, ix); chk("R9 w1", rd, ref_mem[1*NB+1]);
    do_cmd(1'b0, 3'd6);
    host_word(1'b0, '0, rd, ix); chk("R9 w2", rd, ref_mem[1*NB+2]);
    host_word(1'b0, '0, rd, ix); chk("R9 w3", rd, ref_mem[1*NB+3]);
    chk("R9 ready after swap", host_ready, 1);
    chk("R9 idx after swap", host_idx, 0);
    chk("R9 next row word0", host_rdata, ref_mem[6*NB]);
    read_row(3'd6, "R9 second set");
    chk("R10 empty after both", host_ready, 0);
  endtask

  task automatic t_stall();
    logic [W-1:0] rd; logic [BB-1:0] ix;
    do_cmd(1'b0, 3'd3);
    for (int i = 0; i < NB-1; i++) host_word(1'b0, '0, rd, ix);
    cmd_valid = 1'b1; cmd_wr = 0; cmd_row = 3'd4;
    host_valid = 1'b1; host_we = 0; #1;
    chk("R8 held by request", host_ready, 0);
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; #1;
    chk("R8 held issue", host_ready, 0);
    @(negedge clk); #1;
    chk("R8 held capt", host_ready, 0);
    @(negedge clk); #1;
    chk("R8 released", host_ready, 1);
    chk("R8 last word", host_rdata, ref_mem[3*NB+NB-1]);
    @(posedge clk); @(negedge clk);
    host_valid = 1'b0; #1;
    chk("R9 swap ready", host_ready, 1);
    chk("R9 swap word0", host_rdata, ref_mem[4*NB]);
    read_row(3'd4, "R8 next row");
  endtask

  initial begin
    t_reset();
    t_fill();
    t_read(3'd0);
    t_read(3'd7);
    t_ignore();
    t_double();
    t_stall();
    write_row(3'd7, 99);
    t_read(3'd7);
    t_read(3'd2);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule